// File: doc/BRIEF.md
# Precision-time slave offset and delay calculator

This block sits on the slave side of a precision-time link. It receives the four timestamps of a time-transfer exchange, already extracted from the packets, each with the sequence identifier of its message. From them it works out how far the local time counter must be moved, and how long the path to the master is. Packets are not parsed here, and the block has no filtering and no frequency servo.

The work comes in two phases. In the offset phase, a Sync arrival time is paired with the exact master send time carried by the matching Follow_Up. The correction is issued only once both are present. Once a mean path delay is known, it is taken out of the correction. In the delay phase, a fresh Sync/Follow_Up pair gives the master-to-slave delay. The Delay_Request send time and the master arrival time returned in the Delay_Response give the slave-to-master delay. Their average is the mean path delay, and the block also issues a final correction based on it. Offset phases repeat every Sync interval. A control input sets how many offset phases separate two delay phases.

Timestamps enter on one valid/ready stream. The producer must hold kind, sequence and time stable while `ts_valid` is high and `ts_ready` is low. A word is taken on a clock edge where both are high. `ts_ready` drops only while a result is being computed. The two result outputs are single-cycle strobes with no back-pressure. The local time counter must act on them in the cycle they are high.

Top module: `ptp_slave_calc`

## Requirements
- R1: After reset, `ts_ready` is 1, both strobes are 0, and both result values are zero.
- R2: In the offset phase, a Follow_Up (kind 1) whose sequence equals that of the pending Sync (kind 0) raises `ofs_valid`. This happens exactly one cycle after the accepting edge, with the value Sync arrival time minus Follow_Up time minus the current mean delay. Before the first delay result the mean delay is zero, so the first correction is the raw difference.
- R3: Offset corrections after a delay result subtract the mean delay from the latest delay result.
- R4: In the delay phase, the matched Follow_Up produces no strobe and records ms = Sync time minus Follow_Up time. A Delay_Response (kind 3) that matches the pending Delay_Request (kind 2) gives sm = response time minus request time. Exactly three cycles after the accepting edge, `dly_valid` and `ofs_valid` rise together. The mean is floor((ms+sm)/2), computed as an arithmetic shift right by one, and the correction is ms minus the mean.
- R5: A Follow_Up or Delay_Response whose sequence does not match is discarded, and its phase returns to waiting for a new Sync or Delay_Request. A Follow_Up with no pending Sync is ignored.
- R6: A new Sync, or a new Delay_Request, arriving while its partner is awaited replaces the pending one.
- R7: Kinds that the current step does not expect are accepted and have no effect. This includes a Delay_Request or Delay_Response during the offset phase, and a Sync while a Delay_Request is awaited.
- R8: The first delay phase follows the first offset correction after reset. After each delay result, `dly_interval` offset corrections occur before the next delay phase. A value of 0 runs delay phases back to back.
- R9: Times are 48-bit unsigned seconds plus 32-bit nanoseconds below 10^9. Every result is signed 50-bit seconds plus nanoseconds in [0, 10^9), with value sec·10^9+ns. Borrows and carries cross the 10^9 boundary.
- R10: `ts_ready` is low for one cycle after a matched offset-phase Follow_Up and for three cycles after a matched Delay_Response. A delay-phase Follow_Up does not lower it. Strobes appear only while `ts_ready` is high.
- R11: Each strobe lasts one cycle. The delay output holds its value between `dly_valid` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | Timestamp word offered |
| ts_ready | output | 1 | Block can take a word |
| ts_kind | input | 2 | 0 Sync arrival, 1 Follow_Up time, 2 Delay_Request send, 3 Delay_Response time |
| ts_seq | input | 16 | Sequence identifier of the message |
| ts_sec | input | 48 | Seconds of the time |
| ts_ns | input | 32 | Nanoseconds of the time |
| dly_interval | input | 8 | Offset corrections between delay phases |
| ofs_valid | output | 1 | Correction strobe |
| ofs_sec | output | 50 | Signed seconds of correction (to subtract from local time) |
| ofs_ns | output | 32 | Nanoseconds of correction |
| dly_valid | output | 1 | Mean delay strobe |
| dly_sec | output | 50 | Signed seconds of mean path delay |
| dly_ns | output | 32 | Nanoseconds of mean path delay |

## Verification
An offset-phase correction is due one cycle after the edge that takes the matching Follow_Up. The mean delay and its correction are due three cycles after the edge that takes the matching Delay_Response. The driver notes the cycle of each accepting edge and queues every expected result with its due cycle. The monitor compares both the value and the cycle of each strobe, sampling on the falling edge. Any strobe with nothing queued fails, so a discarded or ignored message is checked by the absence of output and by the correctness of the results that follow it.

// File: rtl/ptp_calc_pkg.sv
package ptp_calc_pkg;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 32;
  localparam int SPAN_W = SEC_W + 2;
  localparam logic [NS_W-1:0] NS_PER_SEC = NS_W'(1000000000);
  localparam logic [NS_W-1:0] NS_HALF    = NS_W'(500000000);

  typedef enum logic [1:0] {
    K_SYNC = 2'd0,
    K_FUP  = 2'd1,
    K_DREQ = 2'd2,
    K_DRSP = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    OP_OFS = 2'd0,
    OP_MS  = 2'd1,
    OP_SM  = 2'd2
  } calc_op_e;

  // value = sec * 1e9 + ns, with ns held in [0, 1e9)
  typedef struct packed {
    logic signed [SPAN_W-1:0] sec;
    logic [NS_W-1:0]          ns;
  } span_t;

  function automatic span_t ts_to_span(logic [SEC_W-1:0] s, logic [NS_W-1:0] n);
    span_t r;
    r.sec = $signed({2'b00, s});
    r.ns  = n;
    return r;
  endfunction

  function automatic span_t span_sub(span_t a, span_t b);
    span_t r;
    logic signed [NS_W:0] dn;
    dn    = $signed({1'b0, a.ns}) - $signed({1'b0, b.ns});
    r.sec = a.sec - b.sec;
    if (dn < 0) begin
      dn    = dn + $signed({1'b0, NS_PER_SEC});
      r.sec = r.sec - SPAN_W'(1);
    end
    r.ns = dn[NS_W-1:0];
    return r;
  endfunction

  function automatic span_t span_add(span_t a, span_t b);
    span_t r;
    logic [NS_W:0] sn;
    sn    = {1'b0, a.ns} + {1'b0, b.ns};
    r.sec = a.sec + b.sec;
    if (sn >= {1'b0, NS_PER_SEC}) begin
      sn    = sn - {1'b0, NS_PER_SEC};
      r.sec = r.sec + SPAN_W'(1);
    end
    r.ns = sn[NS_W-1:0];
    return r;
  endfunction

  // floor(value / 2): shift seconds, move the odd second into nanoseconds
  function automatic span_t span_half(span_t a);
    span_t r;
    r.sec = a.sec >>> 1;
    r.ns  = (a.ns >> 1) + (a.sec[0] ? NS_HALF : '0);
    return r;
  endfunction
endpackage

// File: rtl/ptp_phase_fsm.sv
module ptp_phase_fsm
  import ptp_calc_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [1:0]       kind,
  input  logic [SEQ_W-1:0] seq,
  input  span_t            stamp,
  input  logic [CNT_W-1:0] dly_interval,
  output logic             go,
  output calc_op_e         op,
  output span_t            opa,
  output span_t            opb
);
  typedef enum logic [2:0] {
    P_OWS, P_OWF, P_DWS, P_DWF, P_DWQ, P_DWR
  } phase_e;

  phase_e           st;
  span_t            pend_ts;
  logic [SEQ_W-1:0] pend_seq;
  logic [CNT_W-1:0] cnt;
  logic             have_dly;
  logic             seq_hit;
  logic             last_ofs;

  assign seq_hit  = (seq == pend_seq);
  assign last_ofs = !have_dly ||
                    (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, dly_interval});

  always_comb begin
    go  = 1'b0;
    op  = OP_OFS;
    opa = pend_ts;
    opb = stamp;
    case (st)
      P_OWF: if (acc && kind == K_FUP && seq_hit) go = 1'b1;
      P_DWF: if (acc && kind == K_FUP && seq_hit) begin
        go = 1'b1;
        op = OP_MS;
      end
      P_DWR: if (acc && kind == K_DRSP && seq_hit) begin
        go  = 1'b1;
        op  = OP_SM;
        opa = stamp;
        opb = pend_ts;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= P_OWS;
      pend_ts  <= '0;
      pend_seq <= '0;
      cnt      <= '0;
      have_dly <= 1'b0;
    end else if (acc) begin
      case (st)
        P_OWS, P_DWS: if (kind == K_SYNC) begin
          pend_ts  <= stamp;
          pend_seq <= seq;
          st       <= (st == P_OWS) ? P_OWF : P_DWF;
        end
        P_OWF: begin
          if (kind == K_SYNC) begin
            pend_ts  <= stamp;
            pend_seq <= seq;
          end else if (kind == K_FUP) begin
            if (seq_hit) begin
              cnt <= cnt + CNT_W'(1);
              st  <= last_ofs ? P_DWS : P_OWS;
            end else begin
              st <= P_OWS;
            end
          end
        end
        P_DWF: begin
          if (kind == K_SYNC) begin
            pend_ts  <= stamp;
            pend_seq <= seq;
          end else if (kind == K_FUP) begin
            st <= seq_hit ? P_DWQ : P_DWS;
          end
        end
        P_DWQ: if (kind == K_DREQ) begin
          pend_ts  <= stamp;
          pend_seq <= seq;
          st       <= P_DWR;
        end
        P_DWR: begin
          if (kind == K_DREQ) begin
            pend_ts  <= stamp;
            pend_seq <= seq;
          end else if (kind == K_DRSP) begin
            if (seq_hit) begin
              have_dly <= 1'b1;
              cnt      <= '0;
              st       <= (dly_interval == '0) ? P_DWS : P_OWS;
            end else begin
              st <= P_DWQ;
            end
          end
        end
        default: st <= P_OWS;
      endcase
    end
  end
endmodule

// File: rtl/ptp_span_unit.sv
module ptp_span_unit
  import ptp_calc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  calc_op_e op,
  input  span_t    opa,
  input  span_t    opb,
  output logic     idle,
  output logic     ofs_valid,
  output span_t    ofs,
  output logic     dly_valid,
  output span_t    dly
);
  typedef enum logic [2:0] {U_IDLE, U_OFS, U_SUM, U_HALF, U_FIN} ustate_e;

  ustate_e us;
  span_t   diff;
  span_t   d_q;
  span_t   ms_q;
  span_t   sum_q;
  span_t   mean_q;

  assign diff = span_sub(opa, opb);
  assign idle = (us == U_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      us        <= U_IDLE;
      d_q       <= '0;
      ms_q      <= '0;
      sum_q     <= '0;
      mean_q    <= '0;
      ofs       <= '0;
      dly       <= '0;
      ofs_valid <= 1'b0;
      dly_valid <= 1'b0;
    end else begin
      ofs_valid <= 1'b0;
      dly_valid <= 1'b0;
      case (us)
        U_IDLE: if (go) begin
          case (op)
            OP_OFS: begin
              d_q <= diff;
              us  <= U_OFS;
            end
            OP_MS: ms_q <= diff;
            OP_SM: begin
              d_q <= diff;
              us  <= U_SUM;
            end
            default: ;
          endcase
        end
        U_OFS: begin
          ofs       <= span_sub(d_q, mean_q);
          ofs_valid <= 1'b1;
          us        <= U_IDLE;
        end
        U_SUM: begin
          sum_q <= span_add(ms_q, d_q);
          us    <= U_HALF;
        end
        U_HALF: begin
          mean_q <= span_half(sum_q);
          us     <= U_FIN;
        end
        U_FIN: begin
          ofs       <= span_sub(ms_q, mean_q);
          dly       <= mean_q;
          ofs_valid <= 1'b1;
          dly_valid <= 1'b1;
          us        <= U_IDLE;
        end
        default: us <= U_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptp_slave_calc.sv
module ptp_slave_calc
  import ptp_calc_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ts_valid,
  output logic                     ts_ready,
  input  logic [1:0]               ts_kind,
  input  logic [SEQ_W-1:0]         ts_seq,
  input  logic [SEC_W-1:0]         ts_sec,
  input  logic [NS_W-1:0]          ts_ns,
  input  logic [CNT_W-1:0]         dly_interval,
  output logic                     ofs_valid,
  output logic signed [SPAN_W-1:0] ofs_sec,
  output logic [NS_W-1:0]          ofs_ns,
  output logic                     dly_valid,
  output logic signed [SPAN_W-1:0] dly_sec,
  output logic [NS_W-1:0]          dly_ns
);
  logic     acc;
  logic     go;
  logic     idle;
  calc_op_e op;
  span_t    stamp;
  span_t    opa;
  span_t    opb;
  span_t    ofs;
  span_t    dly;

  assign ts_ready = idle;
  assign acc      = ts_valid && idle;
  assign stamp    = ts_to_span(ts_sec, ts_ns);

  ptp_phase_fsm #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc          (acc),
    .kind         (ts_kind),
    .seq          (ts_seq),
    .stamp        (stamp),
    .dly_interval (dly_interval),
    .go           (go),
    .op           (op),
    .opa          (opa),
    .opb          (opb)
  );

  ptp_span_unit i_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .idle      (idle),
    .ofs_valid (ofs_valid),
    .ofs       (ofs),
    .dly_valid (dly_valid),
    .dly       (dly)
  );

  assign ofs_sec = ofs.sec;
  assign ofs_ns  = ofs.ns;
  assign dly_sec = dly.sec;
  assign dly_ns  = dly.ns;
endmodule

// File: rtl/ptp_calc_chk.sv
module ptp_calc_chk
  import ptp_calc_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ts_ready,
  input logic                     ofs_valid,
  input logic [NS_W-1:0]          ofs_ns,
  input logic                     dly_valid,
  input logic signed [SPAN_W-1:0] dly_sec,
  input logic [NS_W-1:0]          dly_ns
);
  // R11
  ofs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_valid |=> !ofs_valid);
  // R11
  dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_valid |-> $stable({dly_sec, dly_ns}));
  // R4
  dly_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_valid |-> ofs_valid);
  // R9
  ofs_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_valid |-> (ofs_ns < NS_PER_SEC));
  // R9
  dly_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_valid |-> (dly_ns < NS_PER_SEC));
  // R10
  dly_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_valid |-> !$past(ts_ready));
  // R10
  out_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_valid |-> ts_ready);
endmodule

bind ptp_slave_calc ptp_calc_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ts_ready  (ts_ready),
  .ofs_valid (ofs_valid),
  .ofs_ns    (ofs_ns),
  .dly_valid (dly_valid),
  .dly_sec   (dly_sec),
  .dly_ns    (dly_ns)
);

// File: tb/test_ptp_slave_calc.sv
module test_ptp_slave_calc;
  import ptp_calc_pkg::*;

  localparam longint GIGA = 1000000000;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     ts_valid;
  logic                     ts_ready;
  logic [1:0]               ts_kind;
  logic [15:0]              ts_seq;
  logic [SEC_W-1:0]         ts_sec;
  logic [NS_W-1:0]          ts_ns;
  logic [7:0]               dly_interval;
  logic                     ofs_valid;
  logic signed [SPAN_W-1:0] ofs_sec;
  logic [NS_W-1:0]          ofs_ns;
  logic                     dly_valid;
  logic signed [SPAN_W-1:0] dly_sec;
  logic [NS_W-1:0]          dly_ns;

  always #10 clk = ~clk;

  ptp_slave_calc i_ptp_slave_calc (
    .clk(clk), .rst_n(rst_n), .ts_valid(ts_valid), .ts_ready(ts_ready),
    .ts_kind(ts_kind), .ts_seq(ts_seq), .ts_sec(ts_sec), .ts_ns(ts_ns),
    .dly_interval(dly_interval), .ofs_valid(ofs_valid), .ofs_sec(ofs_sec),
    .ofs_ns(ofs_ns), .dly_valid(dly_valid), .dly_sec(dly_sec), .dly_ns(dly_ns)
  );

  typedef struct {
    longint val;
    int     due;
    string  req;
  } exp_t;

  exp_t   ofs_q[$];
  exp_t   dly_q[$];
  exp_t   me;
  int     cyc = 0;
  int     nvec = 0;
  int     nbad = 0;
  longint mean_m = 0;
  longint ms_m = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_val(string req, string what, longint act, longint exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_span(string req, string what, logic signed [SPAN_W-1:0] s,
                            logic [NS_W-1:0] n, longint exp);
    longint es;
    longint en;
    es = exp / GIGA;
    if (exp % GIGA < 0) es = es - 1;
    en = exp - es * GIGA;
    nvec++;
    if (longint'(s) != es || longint'(n) != en) begin
      nbad++;
      $display("FAIL %s %s: actual %0d s %0d ns expected %0d s %0d ns",
               req, what, longint'(s), longint'(n), es, en);
    end
  endtask

  // monitor: pops the scoreboard on every strobe, checks value and due cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (ofs_valid) begin
        if (ofs_q.size() == 0) begin
          nvec++; nbad++;
          $display("FAIL R7 unexpected correction: actual strobe expected none");
        end else begin
          me = ofs_q.pop_front();
          check_span(me.req, "correction", ofs_sec, ofs_ns, me.val);
          check_val(me.req, "correction cycle", cyc, me.due);
        end
      end
      if (dly_valid) begin
        if (dly_q.size() == 0) begin
          nvec++; nbad++;
          $display("FAIL R4 unexpected delay: actual strobe expected none");
        end else begin
          me = dly_q.pop_front();
          check_span(me.req, "mean delay", dly_sec, dly_ns, me.val);
          check_val(me.req, "mean delay cycle", cyc, me.due);
        end
      end
    end
  end

  task automatic send(logic [1:0] k, int sq, longint t, output int acc_cyc);
    longint s;
    longint n;
    s = t / GIGA;
    n = t % GIGA;
    @(negedge clk);
    ts_valid = 1'b1;
    ts_kind  = k;
    ts_seq   = sq[15:0];
    ts_sec   = SEC_W'(s);
    ts_ns    = NS_W'(n);
    while (!ts_ready) @(negedge clk);
    acc_cyc = cyc + 1;
    @(posedge clk);
    #1 ts_valid = 1'b0;
  endtask

  task automatic push(bit is_dly, longint v, int due, string req);
    exp_t e;
    e.val = v; e.due = due; e.req = req;
    if (is_dly) dly_q.push_back(e);
    else ofs_q.push_back(e);
  endtask

  task automatic offset_round(int sq, longint t2, longint t1, string req);
    int c;
    send(K_SYNC, sq, t2, c);
    send(K_FUP, sq, t1, c);
    push(1'b0, (t2 - t1) - mean_m, c + 1, req);
  endtask

  task automatic delay_round(int sq1, longint t2, longint t1,
                             int sq2, longint t3, longint t4, string req);
    int c;
    longint sm;
    send(K_SYNC, sq1, t2, c);
    send(K_FUP, sq1, t1, c);
    ms_m = t2 - t1;
    @(negedge clk);
    check_val("R10", "ready after delay-phase follow-up", ts_ready, 1);
    send(K_DREQ, sq2, t3, c);
    send(K_DRSP, sq2, t4, c);
    sm = t4 - t3;
    mean_m = (ms_m + sm) >>> 1;
    push(1'b1, mean_m, c + 3, req);
    push(1'b0, ms_m - mean_m, c + 3, req);
    @(negedge clk);
    check_val("R10", "ready while delay computes", ts_ready, 0);
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int c;
    longint S;
    S = GIGA;
    rst_n = 1'b0;
    ts_valid = 1'b0;
    ts_kind = '0;
    ts_seq = '0;
    ts_sec = '0;
    ts_ns = '0;
    dly_interval = 8'd2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check_val("R1", "ready", ts_ready, 1);
    check_val("R1", "ofs_valid", ofs_valid, 0);
    check_val("R1", "dly_valid", dly_valid, 0);
    check_val("R1", "delay value", longint'(dly_sec) + longint'(dly_ns), 0);
    check_val("R1", "correction value", longint'(ofs_sec) + longint'(ofs_ns), 0);

    // R7: delay messages in the offset phase; R5: follow-up with no pending sync
    send(K_DREQ, 1, 50 * S, c);
    send(K_DRSP, 1, 50 * S, c);
    send(K_FUP, 1, 50 * S, c);
    // R2 first correction is the raw difference, with a nanosecond borrow (R9)
    offset_round(1, 100 * S + 5000, 99 * S + 999999000, "R2");
    @(negedge clk);
    check_val("R10", "ready low after offset follow-up", ts_ready, 0);
    // R8: delay phase follows first correction; negative results (R9)
    delay_round(2, 101 * S + 100, 101 * S + 300, 7, 101 * S + 999999900, 102 * S + 500, "R4");
    // R3: two corrections remove the mean delay
    offset_round(3, 110 * S + 1000, 109 * S + 2000, "R3");
    offset_round(4, 120 * S, 120 * S + 50, "R3");

    // delay phase with mismatches (R5) and replacements (R6)
    send(K_SYNC, 10, 125 * S, c);
    send(K_FUP, 11, 125 * S, c);
    send(K_FUP, 10, 125 * S, c);
    send(K_SYNC, 12, 128 * S, c);
    send(K_SYNC, 13, 130 * S, c);
    send(K_FUP, 13, 131 * S + 1, c);
    ms_m = (130 * S) - (131 * S + 1);
    send(K_DRSP, 5, 132 * S, c);
    send(K_SYNC, 14, 133 * S, c);
    send(K_DREQ, 20, 135 * S, c);
    send(K_DRSP, 21, 135 * S + 9, c);
    send(K_DRSP, 20, 135 * S + 9, c);
    send(K_DREQ, 22, 139 * S, c);
    send(K_DREQ, 23, 140 * S + 500, c);
    send(K_DRSP, 23, 140 * S + 500, c);
    mean_m = (ms_m + 0) >>> 1;
    push(1'b1, mean_m, c + 3, "R5");
    push(1'b0, ms_m - mean_m, c + 3, "R6");

    // R8: two corrections, then delay; then back-to-back delay phases
    offset_round(30, 150 * S + 700, 150 * S + 100, "R8");
    offset_round(31, 151 * S, 150 * S + 999999999, "R8");
    dly_interval = 8'd0;
    delay_round(32, 160 * S + 10, 160 * S + 10, 33, 160 * S + 100, 160 * S + 131, "R8");
    delay_round(34, 170 * S + 20, 170 * S, 35, 170 * S + 999999990, 171 * S + 10, "R8");

    repeat (10) @(negedge clk);
    check_val("R11", "leftover corrections", ofs_q.size(), 0);
    check_val("R11", "leftover delays", dly_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule